// File: doc/BRIEF.md
# Sized Negate Unit

This execution slice forms the two's-complement negation of an operand that is one byte, one 16-bit word or one 32-bit longword wide, and produces five condition flags for it: half-borrow (H), sign (N), zero (Z), overflow (V) and carry (C). The operand comes either from a 32-bit register value or from a memory data value, chosen by a source select. A register-sourced result is merged into the register's low bits so that bits above the operand size keep their old contents. A memory-sourced result is presented zero-extended for write-back, with its own write enable.

All outputs are registered and change only on a clock edge where the execute strobe is high. Between strobes the flags, the merged register value and the memory result hold, so the surrounding pipeline can read them at leisure. Fetch, decode and the memory bus belong to the surrounding core.

Top module: `sized_negate_unit`

## Requirements
- R1: With size code 2'b00 and register source, one cycle after the strobe reg_out equals the register input with bits 7:0 replaced by the negated low byte and bits 31:8 unchanged, and reg_we is high for that one cycle.
- R2: With size code 2'b01 and register source, reg_out carries the negated low 16 bits in bits 15:0 and the input's bits 31:16 unchanged.
- R3: With size code 2'b10 the whole 32-bit value is negated; size code 2'b11 behaves exactly like 2'b10.
- R4: With memory source (mem_sel high) the operand is the sized low part of mem_in, mem_out carries the zero-extended sized result, mem_we is high for one cycle, reg_we stays low and reg_out keeps its previous value.
- R5: C is set when the sized operand is non-zero and cleared only when it is zero.
- R6: Z is set exactly when the sized result is zero; N equals the top bit of the sized result.
- R7: V is set only when the sized operand is the most negative value of its size (0x80, 0x8000, 0x80000000); the result then equals the operand.
- R8: H is the borrow out of bit 3 (byte), bit 11 (word) or bit 27 (longword) of 0 minus the operand, i.e. set when any operand bit below that position is one.
- R9: While the strobe is low, reg_out, mem_out and all flags hold their values and both write enables are low, whatever the other inputs do.
- R10: Synchronous reset clears reg_out, mem_out, both write enables and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid | input | 1 | Execute strobe; results are captured on this edge |
| size_sel | input | 2 | Operand size: 00 byte, 01 word, 10 or 11 longword |
| mem_sel | input | 1 | 1 takes the operand from mem_in, 0 from reg_in |
| reg_in | input | 32 | Current destination register value |
| mem_in | input | 32 | Memory operand, sized part in the low bits |
| reg_out | output | 32 | Register value with the result merged by size |
| mem_out | output | 32 | Zero-extended result for memory write-back |
| reg_we | output | 1 | One-cycle register write enable |
| mem_we | output | 1 | One-cycle memory write enable |
| flag_h | output | 1 | Half-borrow flag |
| flag_n | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Every result is due exactly one clock edge after the edge that sees the strobe: the bench raises the strobe at a falling edge, drops it at the next falling edge, and reads all outputs at that second falling edge, when the write enables show their one-cycle pulse. Bytes are swept over all 256 values, words over a strided sweep plus boundary values, and longwords over a hashed sweep plus the zero, one and most-negative corners; expected results and flags are computed arithmetically in the bench. The hold behaviour is checked by several idle cycles with changing inputs, sampled at the same falling-edge points.

// File: rtl/negu_pkg.sv
package negu_pkg;

    // number of operand sizes, each double the previous, starting at a byte
    localparam int LANES  = 3;
    localparam int DATA_W = 8 << (LANES - 1);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_ALT  = 2'b11
    } opsize_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // lane index picked by a size code; unknown codes fall to the widest lane
    function automatic int unsigned size_to_lane(input opsize_e sz);
        case (sz)
            SZ_BYTE: return 0;
            SZ_WORD: return 1;
            default: return LANES - 1;
        endcase
    endfunction

endpackage

// File: rtl/negu_lane.sv
module negu_lane
    import negu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd,
    output logic [W-1:0] res,
    output ccr_t         fl
);
    localparam int HB = W - 4;   // borrow position of the half flag

    always_comb begin
        res  = '0 - opnd;
        fl.c = |opnd;
        fl.z = ~|res;
        fl.n = res[W-1];
        fl.v = opnd[W-1] & ~|opnd[W-2:0];
        fl.h = |opnd[HB-1:0];
    end
endmodule

// File: rtl/negu_datapath.sv
module negu_datapath
    import negu_pkg::*;
(
    input  opsize_e           size,
    input  logic              from_mem,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] mem_val,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] sized_res,
    output ccr_t              flags
);
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] lane_res  [LANES];
    logic [DATA_W-1:0] lane_mask [LANES];
    ccr_t              lane_fl   [LANES];

    assign opnd = from_mem ? mem_val : reg_val;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = 8 << g;
        localparam logic [63:0] MASK64 = (64'd1 << LW) - 64'd1;
        logic [LW-1:0] r;

        negu_lane #(.W(LW)) lane_i (
            .opnd (opnd[LW-1:0]),
            .res  (r),
            .fl   (lane_fl[g])
        );

        assign lane_res[g]  = DATA_W'(r);
        assign lane_mask[g] = MASK64[DATA_W-1:0];
    end

    always_comb begin
        int unsigned idx;
        idx       = size_to_lane(size);
        sized_res = lane_res[idx];
        flags     = lane_fl[idx];
        merged    = (reg_val & ~lane_mask[idx]) | lane_res[idx];
    end
endmodule

// File: rtl/sized_negate_unit.sv
module sized_negate_unit
    import negu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        exec_valid,
    input  logic [1:0]  size_sel,
    input  logic        mem_sel,
    input  logic [31:0] reg_in,
    input  logic [31:0] mem_in,
    output logic [31:0] reg_out,
    output logic [31:0] mem_out,
    output logic        reg_we,
    output logic        mem_we,
    output logic        flag_h,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c
);
    logic [DATA_W-1:0] dp_merged;
    logic [DATA_W-1:0] dp_res;
    ccr_t              dp_flags;

    logic [DATA_W-1:0] reg_q;
    logic [DATA_W-1:0] mem_q;
    logic              reg_we_q;
    logic              mem_we_q;
    ccr_t              flags_q;

    negu_datapath dp_i (
        .size      (opsize_e'(size_sel)),
        .from_mem  (mem_sel),
        .reg_val   (reg_in),
        .mem_val   (mem_in),
        .merged    (dp_merged),
        .sized_res (dp_res),
        .flags     (dp_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q    <= '0;
            mem_q    <= '0;
            reg_we_q <= 1'b0;
            mem_we_q <= 1'b0;
            flags_q  <= '0;
        end else begin
            reg_we_q <= exec_valid && !mem_sel;
            mem_we_q <= exec_valid && mem_sel;
            if (exec_valid) begin
                flags_q <= dp_flags;
                if (mem_sel) mem_q <= dp_res;
                else         reg_q <= dp_merged;
            end
        end
    end

    assign reg_out = reg_q;
    assign mem_out = mem_q;
    assign reg_we  = reg_we_q;
    assign mem_we  = mem_we_q;
    assign flag_h  = flags_q.h;
    assign flag_n  = flags_q.n;
    assign flag_z  = flags_q.z;
    assign flag_v  = flags_q.v;
    assign flag_c  = flags_q.c;
endmodule

// File: rtl/negu_checker.sv
module negu_checker (
    input logic        clk,
    input logic        rst,
    input logic        exec_valid,
    input logic        mem_sel,
    input logic [31:0] reg_out,
    input logic [31:0] mem_out,
    input logic        reg_we,
    input logic        mem_we,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c
);
    // a register-sourced execute yields a register write the next cycle
    assert_reg_write_R1: assert property (@(posedge clk) disable iff (rst)
        (exec_valid && !mem_sel) |=> (reg_we && !mem_we));

    // a memory-sourced execute writes memory and leaves the register alone
    assert_mem_write_R4: assert property (@(posedge clk) disable iff (rst)
        (exec_valid && mem_sel) |=> (mem_we && !reg_we && $stable(reg_out)));

    // carry and zero are complementary after any execute
    assert_carry_vs_zero_R5: assert property (@(posedge clk) disable iff (rst)
        exec_valid |=> (flag_c != flag_z));

    // overflow only arises with a negative result
    assert_ovf_sign_R7: assert property (@(posedge clk) disable iff (rst)
        exec_valid |=> (!flag_v || (flag_n && flag_c)));

    // no strobe: everything holds and nothing is written
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !exec_valid |=> ($stable(reg_out) && $stable(mem_out) && $stable(flag_c)
                         && $stable(flag_z) && $stable(flag_n) && $stable(flag_v)
                         && !reg_we && !mem_we));

    // enables never coincide
    assert_single_we_R9: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && mem_we));
endmodule

bind sized_negate_unit negu_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .exec_valid (exec_valid),
    .mem_sel    (mem_sel),
    .reg_out    (reg_out),
    .mem_out    (mem_out),
    .reg_we     (reg_we),
    .mem_we     (mem_we),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .flag_v     (flag_v),
    .flag_c     (flag_c)
);

// File: tb/sized_negate_unit_tb_top.sv
`timescale 1ns/1ps
module sized_negate_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_valid = 1'b0;
    logic [1:0]  size_sel = 2'b00;
    logic        mem_sel = 1'b0;
    logic [31:0] reg_in = '0;
    logic [31:0] mem_in = '0;
    logic [31:0] reg_out, mem_out;
    logic        reg_we, mem_we;
    logic        flag_h, flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_reg = '0;
    logic [31:0] exp_mem = '0;
    logic [4:0]  exp_fl  = '0;

    always #10 clk = ~clk;

    sized_negate_unit dut_i (
        .clk(clk), .rst(rst), .exec_valid(exec_valid), .size_sel(size_sel),
        .mem_sel(mem_sel), .reg_in(reg_in), .mem_in(mem_in),
        .reg_out(reg_out), .mem_out(mem_out), .reg_we(reg_we), .mem_we(mem_we),
        .flag_h(flag_h), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // arithmetic reference: flags packed as {h,n,z,v,c}
    task automatic model(input int w, input logic [31:0] op,
                         output logic [31:0] res, output logic [4:0] fl);
        logic [31:0] m, o;
        m   = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        o   = op & m;
        res = (32'd0 - o) & m;
        fl  = {(o & (m >> 4)) != 0, res[w-1], res == 0, o == (32'd1 << (w-1)), o != 0};
    endtask

    task automatic check_flags();
        chk("R8 flag_h", {31'd0, flag_h}, {31'd0, exp_fl[4]});
        chk("R6 flag_n", {31'd0, flag_n}, {31'd0, exp_fl[3]});
        chk("R6 flag_z", {31'd0, flag_z}, {31'd0, exp_fl[2]});
        chk("R7 flag_v", {31'd0, flag_v}, {31'd0, exp_fl[1]});
        chk("R5 flag_c", {31'd0, flag_c}, {31'd0, exp_fl[0]});
    endtask

    task automatic run_op(input logic [1:0] sz, input logic from_mem,
                          input logic [31:0] rv, input logic [31:0] mv, input string tag);
        int w;
        logic [31:0] res, m;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        @(negedge clk);
        size_sel = sz; mem_sel = from_mem; reg_in = rv; mem_in = mv; exec_valid = 1'b1;
        model(w, from_mem ? mv : rv, res, exp_fl);
        if (from_mem) exp_mem = res;
        else          exp_reg = (rv & ~m) | res;
        @(negedge clk);
        exec_valid = 1'b0;
        chk({tag, " reg_out"}, reg_out, exp_reg);
        chk({tag, " mem_out"}, mem_out, exp_mem);
        chk({tag, " reg_we"}, {31'd0, reg_we}, {31'd0, !from_mem});
        chk({tag, " mem_we"}, {31'd0, mem_we}, {31'd0, from_mem});
        check_flags();
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] wv;
        logic [31:0] lv;
        logic [31:0] corners [6];
        corners = '{32'h0, 32'h1, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'hA5A5_A5A5};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 reg_out", reg_out, 32'h0);
        chk("R10 mem_out", mem_out, 32'h0);
        chk("R10 we", {30'd0, reg_we, mem_we}, 32'h0);
        chk("R10 flags", {27'd0, flag_h, flag_n, flag_z, flag_v, flag_c}, 32'h0);

        // R1: every byte value, upper bits carrying varied patterns
        for (int i = 0; i < 256; i++)
            run_op(2'b00, 1'b0, {8'(i * 7), 8'hA5, 8'(~i), 8'(i)}, 32'h0, "R1");
        run_op(2'b00, 1'b0, 32'hA5A5_A5A5, 32'h0, "R1");
        chk("R1 example", reg_out, 32'hA5A5_A55B);

        // R2: strided word sweep plus boundaries
        for (int i = 0; i < 1024; i++) begin
            wv = 16'(i * 97 + (i >> 3));
            run_op(2'b01, 1'b0, {16'(i * 13 + 5), wv}, 32'h0, "R2");
        end
        for (int i = 0; i < 6; i++)
            run_op(2'b01, 1'b0, {16'h5A3C, corners[i][15:0]}, 32'h0, "R2");
        run_op(2'b01, 1'b0, 32'h1234_8000, 32'h0, "R2");
        run_op(2'b01, 1'b0, 32'h1234_0800, 32'h0, "R2");
        run_op(2'b01, 1'b0, 32'hA5A5_A5A5, 32'h0, "R2");
        chk("R2 example", reg_out, 32'hA5A5_5A5B);

        // R3: longword sweep, corners, and the alternate size code
        for (int i = 0; i < 512; i++) begin
            lv = 32'(i) * 32'h9E37_79B1;
            run_op(2'b10, 1'b0, lv, 32'h0, "R3");
        end
        for (int i = 0; i < 6; i++) begin
            run_op(2'b10, 1'b0, corners[i], 32'h0, "R3");
            run_op(2'b11, 1'b0, corners[i], 32'h0, "R3 alt");
        end
        run_op(2'b10, 1'b0, 32'h0800_0000, 32'h0, "R3");
        run_op(2'b10, 1'b0, 32'hA5A5_A5A5, 32'h0, "R3");
        chk("R3 example", reg_out, 32'h5A5A_5A5B);

        // R4: memory operand for every size, register must keep its value
        for (int i = 0; i < 256; i++)
            run_op(2'(i % 4), 1'b1, 32'hFFFF_FFFF - 32'(i), 32'(i) * 32'h0101_0103, "R4");
        run_op(2'b00, 1'b1, 32'h0, 32'h1234_5680, "R4");
        run_op(2'b01, 1'b1, 32'h0, 32'hFFFF_0000, "R4");
        run_op(2'b10, 1'b1, 32'h0, 32'h8000_0000, "R4");

        // R9: idle cycles with busy inputs
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            size_sel = 2'(i); mem_sel = i[0]; reg_in = 32'(i) * 32'h1111_1111;
            mem_in = ~reg_in;
            @(negedge clk);
            chk("R9 reg_out", reg_out, exp_reg);
            chk("R9 mem_out", mem_out, exp_mem);
            chk("R9 we", {30'd0, reg_we, mem_we}, 32'h0);
            chk("R9 flags", {27'd0, flag_h, flag_n, flag_z, flag_v, flag_c}, {27'd0, exp_fl});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule